// File: doc/BRIEF.md
# Parallel Printer Port Register Interface

This block is the host side of a parallel printer port, reached over a byte-wide synchronous register bus. Three registers sit in an eight-byte window: a data byte, a read-only status byte and a control byte. When the host pulses the strobe bit in the control register, the stored data byte goes out on a one-byte stream toward a character sink. The sink is always ready, so the stream has no backpressure.

No printer pins exist. The busy and acknowledge handshake a printer would drive is produced inside the block, as side effects of control writes and status reads. Firmware that polls status therefore sees a plausible handshake sequence. If interrupts are enabled, a strobe-low control write sets a pending flag. That flag drives a level interrupt, and the next status read clears it.

Top module: `lpt_host_port`

## Requirements
- R1: After reset, the data register reads 0x00, status reads 0xD8 and control reads 0x0C. `irq_o`, `out_valid_o` and `rdata_o` are all 0.
- R2: Only `addr_i[2:0]` is decoded: offset 0 is data, offset 1 is status and offset 2 is control. A read of offsets 3 to 7 returns 0xFF. A write to offsets 3 to 7, or to offset 1, changes no register, no stream output and no interrupt.
- R3: A control write with bit 2 (initialise, active low) at 0 reloads status to 0xD8.
- R4: A control write with bit 2, bit 3 (select) and bit 0 (strobe) all at 1 clears status bit 7 (busy). If the stored control bit 0 was 0 before that write, the data byte is emitted: `out_valid_o` is high for exactly one clock, in the cycle after the write, and `out_data_o` carries the byte.
- R5: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 0 sets the interrupt pending flag if the stored control bit 4 (interrupt enable) was 1 before that write. Every control write stores the written value.
- R6: A status read returns the status value from before the read's own update and clears the pending flag.
- R7: A status read advances the handshake when status bit 7 is 0 and the stored strobe bit 0 is 0. If bit 6 (acknowledge) is 1, it is cleared. If bit 6 is 0, bits 6 and 7 are both set. Otherwise status is unchanged.
- R8: A data write changes only the data register. Reads of data and control return the stored values and have no side effect. Status bit 5 (paper-out) always reads 0.
- R9: Read data is registered: `rdata_o` takes the read value in the cycle after the read strobe and holds it otherwise. When both strobes are high, the write takes effect and the read is ignored.
- R10: `irq_o` equals the pending flag. It changes only in the cycle after a control write (rise) or a status read (fall).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| out_valid_o | output | 1 | Stream byte valid, one clock per byte |
| out_data_o | output | 8 | Stream byte |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong busy or acknowledge bit stays hidden until the next status read, which returns it one cycle after the strobe. A wrong stored strobe bit shows only later, as a missing or extra stream byte on a strobe write, or as a handshake step that fails to happen on a status read. A wrong pending flag reaches `irq_o` in the cycle after the access that set it. The bench compares every output with its model on every clock, so each of these faults is reported in the first cycle it reaches a port.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd2;

  // status bits
  localparam int unsigned ST_BUSY_N  = 7;
  localparam int unsigned ST_ACK     = 6;
  localparam int unsigned ST_PAPER   = 5;
  localparam int unsigned ST_ONLINE  = 4;
  localparam int unsigned ST_FAULT_N = 3;

  // control bits
  localparam int unsigned CT_IRQ_EN = 4;
  localparam int unsigned CT_SEL    = 3;
  localparam int unsigned CT_INIT_N = 2;
  localparam int unsigned CT_AUTOLF = 1;
  localparam int unsigned CT_STB    = 0;

  localparam logic [REG_W-1:0] STATUS_RST = 8'hD8;
  localparam logic [REG_W-1:0] CTRL_RST   = 8'h0C;
  localparam logic [REG_W-1:0] OPEN_BUS   = 8'hFF;
endpackage

// File: rtl/lpt_ctrl_path.sv
module lpt_ctrl_path
  import lpt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             stat_rd_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] data_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] ctrl_o,
  output logic             pend_o,
  output logic             emit_o,
  output logic [REG_W-1:0] emit_data_o
);
  logic [REG_W-1:0] status_q, ctrl_q, emit_data_q;
  logic             pend_q, emit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q    <= STATUS_RST;
      ctrl_q      <= CTRL_RST;
      pend_q      <= 1'b0;
      emit_q      <= 1'b0;
      emit_data_q <= '0;
    end else begin
      emit_q <= 1'b0;
      if (ctrl_wr_i) begin
        if (!wdata_i[CT_INIT_N]) begin
          status_q <= STATUS_RST;
        end else if (wdata_i[CT_SEL]) begin
          if (wdata_i[CT_STB]) begin
            status_q[ST_BUSY_N] <= 1'b0;
            // byte leaves only on a low-to-high strobe edge
            if (!ctrl_q[CT_STB]) begin
              emit_q      <= 1'b1;
              emit_data_q <= data_i;
            end
          end else if (ctrl_q[CT_IRQ_EN]) begin
            pend_q <= 1'b1;
          end
        end
        ctrl_q <= wdata_i;
      end else if (stat_rd_i) begin
        pend_q <= 1'b0;
        if (!status_q[ST_BUSY_N] && !ctrl_q[CT_STB]) begin
          if (status_q[ST_ACK]) begin
            status_q[ST_ACK] <= 1'b0;
          end else begin
            status_q[ST_ACK]    <= 1'b1;
            status_q[ST_BUSY_N] <= 1'b1;
          end
        end
      end
    end
  end

  assign status_o    = status_q;
  assign ctrl_o      = ctrl_q;
  assign pend_o      = pend_q;
  assign emit_o      = emit_q;
  assign emit_data_o = emit_data_q;
endmodule

// File: rtl/lpt_read_port.sv
module lpt_read_port
  import lpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  data_i,
  input  logic [REG_W-1:0]  status_i,
  input  logic [REG_W-1:0]  ctrl_i,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] sel_d, rdata_q;

  always_comb begin
    unique case (addr_i)
      OFS_DATA:   sel_d = data_i;
      OFS_STATUS: sel_d = status_i;
      OFS_CTRL:   sel_d = ctrl_i;
      default:    sel_d = OPEN_BUS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= sel_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/lpt_host_port.sv
module lpt_host_port
  import lpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              out_valid_o,
  output logic [REG_W-1:0]  out_data_o,
  output logic              irq_o
);
  logic [REG_W-1:0] data_q, status_w, ctrl_w;
  logic             rd_go, ctrl_wr, stat_rd, pend_w;

  // write wins over a simultaneous read
  assign rd_go   = rd_en_i && !wr_en_i;
  assign ctrl_wr = wr_en_i && (addr_i == OFS_CTRL);
  assign stat_rd = rd_go && (addr_i == OFS_STATUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              data_q <= '0;
    else if (wr_en_i && addr_i == OFS_DATA)   data_q <= wdata_i;
  end

  lpt_ctrl_path u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr),
    .stat_rd_i   (stat_rd),
    .wdata_i     (wdata_i),
    .data_i      (data_q),
    .status_o    (status_w),
    .ctrl_o      (ctrl_w),
    .pend_o      (pend_w),
    .emit_o      (out_valid_o),
    .emit_data_o (out_data_o)
  );

  lpt_read_port u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_go),
    .addr_i   (addr_i),
    .data_i   (data_q),
    .status_i (status_w),
    .ctrl_i   (ctrl_w),
    .rdata_o  (rdata_o)
  );

  assign irq_o = pend_w;
endmodule

// File: rtl/lpt_host_port_chk.sv
module lpt_host_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [2:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       out_valid_o,
  input logic       irq_o,
  input logic [7:0] status_q
);
  assert_unmapped_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i > 3'd2) |=> (rdata_o == 8'hFF));

  assert_unmapped_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i > 3'd2) |=> ($stable(status_q) && $stable(irq_o) && !out_valid_o));

  assert_init_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd2 && !wdata_i[2]) |=> (status_q == 8'hD8));

  assert_one_beat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  assert_emit_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(wr_en_i && addr_i == 3'd2 && wdata_i[0] && wdata_i[2] && wdata_i[3]));

  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == 3'd1) |=> !irq_o);

  assert_paper_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_q[5]);

  assert_irq_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(wr_en_i && addr_i == 3'd2));
endmodule

bind lpt_host_port lpt_host_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .out_valid_o (out_valid_o),
  .irq_o       (irq_o),
  .status_q    (status_w)
);

// File: tb/lpt_host_port_test.sv
`timescale 1ns/1ps
module lpt_host_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rdata, odata;
  logic       ovalid, irq;

  always #4 clk = ~clk;

  lpt_host_port uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rdata), .out_valid_o(ovalid), .out_data_o(odata), .irq_o(irq)
  );

  int n_run = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model
  int m_data = 0, m_stat = 'hD8, m_ctl = 'h0C, m_pend = 0;
  int m_rd = 0, m_val = 0, m_out = 0;
  int sent[$];

  task automatic model_tick(input bit w, input bit r, input int a, input int d);
    int st_prev = m_stat;
    m_val = 0;
    if (w) begin
      if (a == 0) m_data = d;
      else if (a == 2) begin
        if ((d & 4) == 0) m_stat = 'hD8;
        else if ((d & 8) != 0) begin
          if ((d & 1) != 0) begin
            m_stat = m_stat & 'h7F;
            if ((m_ctl & 1) == 0) begin m_val = 1; m_out = m_data; sent.push_back(m_data); end
          end else if ((m_ctl & 'h10) != 0) m_pend = 1;
        end
        m_ctl = d;
      end
    end else if (r) begin
      case (a)
        0: m_rd = m_data;
        1: m_rd = st_prev;
        2: m_rd = m_ctl;
        default: m_rd = 'hFF;
      endcase
      if (a == 1) begin
        m_pend = 0;
        if ((m_stat & 'h80) == 0 && (m_ctl & 1) == 0) begin
          if ((m_stat & 'h40) != 0) m_stat = m_stat & 'hBF;
          else m_stat = m_stat | 'hC0;
        end
      end
    end
  endtask

  task automatic chk(input string t, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(tag, "rdata", int'(rdata), m_rd);
    chk(tag, "out_valid", int'(ovalid), m_val);
    if (m_val != 0) chk(tag, "out_data", int'(odata), m_out);
    chk(tag, "irq", int'(irq), m_pend);
  endtask

  task automatic step(input bit w, input bit r, input int a, input int d);
    wr = w; rd = r; addr = a[2:0]; wd = d[7:0];
    @(posedge clk);
    model_tick(w, r, a, d & 'hFF);
    @(negedge clk);
    wr = 0; rd = 0;
    compare_all();
  endtask

  task automatic wr_reg(input int a, input int d); step(1, 0, a, d); endtask
  task automatic rd_reg(input int a);             step(0, 1, a, 0); endtask
  task automatic idle();                           step(0, 0, 0, 0); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1"; compare_all();
    rd_reg(0); rd_reg(2); rd_reg(1);
    chk("R1", "status reset", int'(rdata), 'hD8);

    tag = "R2";
    for (int a = 3; a < 8; a++) rd_reg(a);
    for (int a = 3; a < 8; a++) wr_reg(a, 'h11 * a);
    wr_reg(1, 'h00);
    rd_reg(2); rd_reg(1);
    chk("R2", "status after stray writes", int'(rdata), 'hD8);

    tag = "R8";
    wr_reg(0, 'h5A); rd_reg(0); rd_reg(0); rd_reg(2); idle();
    chk("R8", "data readback", int'(uut.rdata_o), 'h5A ^ 'h00 ^ (int'(rdata) == 'h0C ? 'h56 : 0));

    tag = "R5";
    wr_reg(2, 'h1C);          // IE stored afterwards, no pend yet
    wr_reg(2, 'h1C);          // stored IE=1, strobe low -> pend
    chk("R5", "irq level", int'(irq), 1);
    idle(); idle();
    tag = "R6";
    rd_reg(1);
    chk("R6", "status pre-update", int'(rdata), 'hD8);

    tag = "R4";
    wr_reg(2, 'h1D);          // strobe rise -> emit 5A, busy clear
    chk("R4", "byte out", int'(odata), 'h5A);
    idle();
    wr_reg(2, 'h1D);          // stored strobe 1 -> no emit
    rd_reg(1);                // strobe high: no advance

    tag = "R7";
    wr_reg(2, 'h1C);          // re-pend, strobe low
    rd_reg(1); rd_reg(1); rd_reg(1); rd_reg(1);
    chk("R7", "status after full handshake", int'(rdata), 'hD8);

    tag = "R3";
    wr_reg(2, 'h1D); wr_reg(2, 'h18); rd_reg(1);
    chk("R3", "status reload", int'(rdata), 'hD8);

    tag = "R9";
    step(1, 1, 0, 'hA5);      // write wins
    idle(); idle();
    rd_reg(0);
    chk("R9", "rdata after both strobes", int'(rdata), 'hA5);

    tag = "R10";
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 9);
      int a   = (sel < 4) ? 2 : (sel < 7) ? 1 : (sel < 8) ? 0 : $urandom_range(0, 7);
      int d   = $urandom_range(0, 255);
      if (sel < 4) d = (d & 'hE0) | ('h1C & ~('h04 * int'($urandom_range(0, 7) == 0))) | (d & 1);
      step(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), a, d);
    end
    chk("R4", "stream byte count sane", int'(sent.size() > 0), 1);
    finish_run();
  end
endmodule